// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a logical address into a physical one for a paged memory system. The low `OFF_W` bits of the logical address are the byte offset inside a page and pass through unchanged. The remaining upper bits form the page number. The page number is first compared against every entry of a small fully associative translation buffer. On a hit, the cached frame number is joined to the offset and the result is returned. On a miss, the unit issues one read of the page-table entry for that page on a simple request/response memory port. A valid entry is written into the buffer, and the lookup then runs again and hits.

Each request carries a write flag. The page number is checked against a table-length input before any lookup. A cleared present bit and a write to a read-only page each return a fault code instead of an address. The first access to a page that leaves its reference bit set emits an update strobe on a dedicated port, and so does the first write that sets its dirty bit, so that the page table can be brought up to date. A flush input empties the buffer in one cycle. Only one translation is in flight at a time, with valid/ready handshakes on the request side and on the response side.

Page-table entry layout, from the least significant bit up: frame number (`FRAME_W` bits), present, read-only, referenced, dirty. Fault codes: 0 = none, 1 = page beyond the table length, 2 = page not present, 3 = write to a read-only page. A faulting response carries a physical address of 0.

Top module: `paged_xlat`

## Requirements
- R1: The physical address is the frame number in the upper bits concatenated with the unchanged offset in the low `OFF_W` bits, that is frame × 2^OFF_W + offset.
- R2: A page found in the translation buffer is answered without any memory read. A page that is missing causes exactly one read, for the entry indexed by that page number, and the translation then completes with the fetched frame.
- R3: A page number greater than or equal to `pt_len` returns fault code 1 and issues no memory read.
- R4: A fetched entry whose present bit (bit `FRAME_W`) is 0 returns fault code 2 and is not cached, so a repeat of the same access reads memory again.
- R5: A write to a page whose read-only bit (bit `FRAME_W+1`) is 1 returns fault code 3 and raises no update strobe. A read of that page translates normally.
- R6: A successful access raises `upd_valid` for one cycle, together with the page number, only when it sets a reference bit that was clear or, for a write, a dirty bit that was clear. `upd_dirty` gives the page's dirty state after the access. Repeating the same kind of access gives no further strobe.
- R7: The buffer has `TLB_N` entries, filled in round-robin order. After `TLB_N` distinct pages are filled, the next fill evicts the oldest one, and the other entries still hit.
- R8: A one-cycle pulse on `flush` invalidates every buffer entry, so the next access to any page reads memory.
- R9: While a translation is in progress `req_ready` is low. A response that is not accepted holds its address and fault code stable until `rsp_ready` is high.
- R10: After reset `req_ready` is high, and `rsp_valid`, `mem_req_valid` and `upd_valid` are low.
- R11: With 4-byte pages, page 0 in frame 5 and page 1 in frame 6, logical address 3 maps to 23, logical address 4 maps to 24 and logical address 0 maps to 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all translation buffer entries |
| pt_len | input | PN_W+1 | Number of pages in the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | LA_W | Logical address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | Fault code |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_page | output | PN_W | Page number whose entry is read |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_pte | input | FRAME_W+4 | Returned page-table entry |
| upd_valid | output | 1 | Reference or dirty bit newly set |
| upd_page | output | PN_W | Page whose bits changed |
| upd_dirty | output | 1 | Dirty state of that page after the access |

## Verification
The hardest state to reach from the ports is round-robin eviction. The replacement pointer is never exposed and keeps running across flushes, so the bench cannot know which slot holds which page. The stimulus flushes the buffer and fills eight distinct pages, which puts every slot back in use no matter where the pointer started. A ninth page must then evict the first page of that run. Counting memory reads on the follow-up accesses shows which page was evicted and which one survived. The update strobe is checked the same way: fresh pages are read and written in sequence, and the strobe must appear only when a bit actually changes.

// File: rtl/paged_xlat.sv
module paged_xlat #(
  parameter int LA_W    = 10,
  parameter int OFF_W   = 2,
  parameter int FRAME_W = 6,
  parameter int TLB_N   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [LA_W-OFF_W:0]      pt_len,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [LA_W-1:0]          req_addr,
  input  logic                     req_write,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]               rsp_fault,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [LA_W-OFF_W-1:0]    mem_req_page,
  input  logic                     mem_rsp_valid,
  input  logic [FRAME_W+3:0]       mem_rsp_pte,
  output logic                     upd_valid,
  output logic [LA_W-OFF_W-1:0]    upd_page,
  output logic                     upd_dirty
);
  localparam int PN_W = LA_W - OFF_W;
  localparam int PA_W = FRAME_W + OFF_W;
  localparam int RR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam int B_PRES = FRAME_W;
  localparam int B_RO   = FRAME_W + 1;
  localparam int B_REF  = FRAME_W + 2;
  localparam int B_DTY  = FRAME_W + 3;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_MREQ, S_MWAIT, S_RESP} st_t;
  st_t st;

  logic [LA_W-1:0]    cur_addr;
  logic               cur_wr;
  logic [RR_W-1:0]    rr;
  logic [TLB_N-1:0]   tv;
  logic [PN_W-1:0]    ttag [TLB_N];
  logic [FRAME_W-1:0] tfrm [TLB_N];
  logic [TLB_N-1:0]   tro, tref, tdty;
  logic [TLB_N-1:0]   hit_vec;
  logic [RR_W-1:0]    hidx;
  logic               hit;

  wire [PN_W-1:0]  cur_pn  = cur_addr[LA_W-1:OFF_W];
  wire [OFF_W-1:0] cur_off = cur_addr[OFF_W-1:0];

  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hit_vec[i] = tv[i] && (ttag[i] == cur_pn);
  end

  always_comb begin
    hidx = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hit_vec[i]) hidx = RR_W'(i);
  end
  assign hit = |hit_vec;

  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RESP);
  assign mem_req_valid = (st == S_MREQ);
  assign mem_req_page  = cur_pn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_addr  <= '0;
      cur_wr    <= 1'b0;
      rr        <= '0;
      tv        <= '0;
      tro       <= '0;
      tref      <= '0;
      tdty      <= '0;
      rsp_paddr <= '0;
      rsp_fault <= 2'd0;
      upd_valid <= 1'b0;
      upd_page  <= '0;
      upd_dirty <= 1'b0;
      for (int i = 0; i < TLB_N; i++) begin
        ttag[i] <= '0;
        tfrm[i] <= '0;
      end
    end else begin
      upd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          cur_wr   <= req_write;
          st       <= S_CHK;
        end
        S_CHK: begin
          if ({1'b0, cur_pn} >= pt_len) begin
            rsp_fault <= 2'd1;
            rsp_paddr <= '0;
            st        <= S_RESP;
          end else if (hit) begin
            if (cur_wr && tro[hidx]) begin
              rsp_fault <= 2'd3;
              rsp_paddr <= '0;
            end else begin
              rsp_fault <= 2'd0;
              rsp_paddr <= PA_W'({tfrm[hidx], cur_off});
              if (!tref[hidx] || (cur_wr && !tdty[hidx])) begin
                upd_valid <= 1'b1;
                upd_page  <= cur_pn;
                upd_dirty <= cur_wr | tdty[hidx];
              end
              tref[hidx] <= 1'b1;
              if (cur_wr) tdty[hidx] <= 1'b1;
            end
            st <= S_RESP;
          end else begin
            st <= S_MREQ;
          end
        end
        S_MREQ: if (mem_req_ready) st <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) begin
          if (mem_rsp_pte[B_PRES]) begin
            tv[rr]   <= 1'b1;
            ttag[rr] <= cur_pn;
            tfrm[rr] <= mem_rsp_pte[FRAME_W-1:0];
            tro[rr]  <= mem_rsp_pte[B_RO];
            tref[rr] <= mem_rsp_pte[B_REF];
            tdty[rr] <= mem_rsp_pte[B_DTY];
            rr       <= (rr == RR_W'(TLB_N-1)) ? '0 : rr + 1'b1;
            st       <= S_CHK;
          end else begin
            rsp_fault <= 2'd2;
            rsp_paddr <= '0;
            st        <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (flush) tv <= '0;
    end
  end
endmodule

module paged_xlat_chk #(
  parameter int PN_W  = 8,
  parameter int PA_W  = 8,
  parameter int TLB_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PN_W:0]    pt_len,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_fault,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PN_W-1:0]  mem_req_page,
  input logic             upd_valid,
  input logic [TLB_N-1:0] hit_vec
);
  assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_read_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ({1'b0, mem_req_page} < pt_len));
  assert_one_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
  assert_mreq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_page)));
  assert_upd_on_success_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (rsp_valid && rsp_fault == 2'd0));
  assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

bind paged_xlat paged_xlat_chk #(.PN_W(PN_W), .PA_W(PA_W), .TLB_N(TLB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pt_len(pt_len), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_page(mem_req_page),
  .upd_valid(upd_valid), .hit_vec(hit_vec)
);

// File: tb/tb_paged_xlat.sv
module tb_paged_xlat;
  localparam int LA_W = 10, OFF_W = 2, FRAME_W = 6, TLB_N = 8;
  localparam int PN_W = LA_W - OFF_W, PA_W = FRAME_W + OFF_W, PTE_W = FRAME_W + 4;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [PN_W:0] pt_len = 9'd64;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, mem_req_ready = 1;
  logic [LA_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_req_valid, upd_valid, upd_dirty;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic [PN_W-1:0] mem_req_page, upd_page;
  logic mem_rsp_valid = 0;
  logic [PTE_W-1:0] mem_rsp_pte = '0;

  int total = 0, bad = 0, rd_cnt = 0, upd_cnt = 0;
  logic [PN_W-1:0] last_upd_page;
  logic last_upd_dirty;
  logic [PTE_W-1:0] pt [256];
  logic pend = 0;
  logic [PN_W-1:0] pend_pg;

  always #4 clk = ~clk;

  paged_xlat #(.LA_W(LA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .TLB_N(TLB_N)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_len(pt_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_page(mem_req_page),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_pte(mem_rsp_pte),
    .upd_valid(upd_valid), .upd_page(upd_page), .upd_dirty(upd_dirty));

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_pte   <= pt[pend_pg];
      pend          <= 1'b0;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend    <= 1'b1;
      pend_pg <= mem_req_page;
      rd_cnt  <= rd_cnt + 1;
    end
    if (rst_n && upd_valid) begin
      upd_cnt        <= upd_cnt + 1;
      last_upd_page  <= upd_page;
      last_upd_dirty <= upd_dirty;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic xlat(input int addr, input bit wr, output int pa, output int f,
                      output int nrd, output int nupd);
    int r0 = rd_cnt, u0 = upd_cnt, n = 0;
    @(negedge clk);
    req_valid = 1; req_addr = LA_W'(addr); req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    if (n >= 100) chk("R9 response timeout", 0, 1);
    pa = int'(rsp_paddr); f = int'(rsp_fault);
    @(negedge clk);
    nrd = rd_cnt - r0; nupd = upd_cnt - u0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    chk("R10 req_ready", int'(req_ready), 1);
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 mem_req_valid", int'(mem_req_valid), 0);
    chk("R10 upd_valid", int'(upd_valid), 0);
  endtask

  task automatic t_example();
    int pa, f, r, u;
    xlat(3, 0, pa, f, r, u);
    chk("R11 la3 paddr", pa, 23); chk("R2 la3 miss reads", r, 1);
    xlat(4, 0, pa, f, r, u);
    chk("R11 la4 paddr", pa, 24); chk("R2 la4 miss reads", r, 1);
    xlat(0, 0, pa, f, r, u);
    chk("R11 la0 paddr", pa, 20); chk("R2 hit no read", r, 0);
    xlat(15, 0, pa, f, r, u);
    chk("R1 la15 paddr", pa, 13 * 4 + 3); chk("R1 la15 fault", f, 0);
  endtask

  task automatic t_range();
    int pa, f, r, u;
    xlat(256, 0, pa, f, r, u);
    chk("R3 fault code", f, 1); chk("R3 no read", r, 0); chk("R3 paddr zero", pa, 0);
    xlat(255, 0, pa, f, r, u);
    chk("R3 last page ok", f, 0); chk("R1 page63 paddr", pa, 9 * 4 + 3);
  endtask

  task automatic t_invalid();
    int pa, f, r, u;
    xlat(80, 0, pa, f, r, u);
    chk("R4 fault code", f, 2); chk("R4 one read", r, 1);
    xlat(81, 0, pa, f, r, u);
    chk("R4 not cached fault", f, 2); chk("R4 not cached reread", r, 1);
  endtask

  task automatic t_protect();
    int pa, f, r, u;
    xlat(13, 1, pa, f, r, u);
    chk("R5 write ro fault", f, 3); chk("R5 no update", u, 0); chk("R5 paddr zero", pa, 0);
    xlat(12, 0, pa, f, r, u);
    chk("R5 read ro ok", f, 0); chk("R5 read paddr", pa, 52);
  endtask

  task automatic t_refdirty();
    int pa, f, r, u;
    xlat(20, 0, pa, f, r, u);
    chk("R6 first read strobe", u, 1); chk("R6 strobe page", int'(last_upd_page), 5);
    chk("R6 read dirty flag", int'(last_upd_dirty), 0);
    xlat(21, 0, pa, f, r, u);
    chk("R6 repeat read no strobe", u, 0);
    xlat(22, 1, pa, f, r, u);
    chk("R6 first write strobe", u, 1); chk("R6 write dirty flag", int'(last_upd_dirty), 1);
    chk("R1 write paddr", pa, 15 * 4 + 2);
    xlat(23, 1, pa, f, r, u);
    chk("R6 repeat write no strobe", u, 0);
  endtask

  task automatic t_roundrobin();
    int pa, f, r, u;
    do_flush();
    for (int p = 30; p < 38; p++) begin
      xlat(p * 4, 0, pa, f, r, u);
      chk("R7 fill read", r, 1);
    end
    xlat(38 * 4, 0, pa, f, r, u);
    chk("R7 ninth fill read", r, 1);
    xlat(31 * 4, 0, pa, f, r, u);
    chk("R7 survivor hits", r, 0);
    chk("R7 survivor paddr", pa, ((31 + 10) % 64) * 4);
    xlat(30 * 4, 0, pa, f, r, u);
    chk("R7 oldest evicted", r, 1);
  endtask

  task automatic t_flush();
    int pa, f, r, u;
    xlat(1, 0, pa, f, r, u);
    xlat(2, 0, pa, f, r, u);
    chk("R8 cached before flush", r, 0);
    do_flush();
    xlat(1, 0, pa, f, r, u);
    chk("R8 miss after flush", r, 1); chk("R8 paddr", pa, 21);
    xlat(1, 0, pa, f, r, u);
    chk("R8 refilled hit", r, 0);
  endtask

  task automatic t_hold();
    int n = 0;
    logic [PA_W-1:0] p0;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 10'd5; req_write = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    p0 = rsp_paddr;
    chk("R9 busy no ready", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9 rsp held", int'(rsp_valid), 1);
    chk("R9 paddr stable", int'(rsp_paddr), int'(p0));
    chk("R9 paddr value", int'(rsp_paddr), 25);
    rsp_ready = 1;
    @(negedge clk);
    chk("R9 released", int'(rsp_valid), 0);
    chk("R9 ready again", int'(req_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++)
      pt[i] = {2'b00, 1'b0, 1'b1, FRAME_W'((i + 10) % 64)};
    pt[0] = {4'b0001, 6'd5};
    pt[1] = {4'b0001, 6'd6};
    pt[3] = {4'b0011, FRAME_W'(13)};
    pt[20] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_example();
    t_range();
    t_invalid();
    t_protect();
    t_refdirty();
    t_roundrobin();
    t_flush();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule